// File: doc/BRIEF.md
# Inbound Segment Address Translator

This block sits at the receive end of a chip-to-chip memory window. Each incoming address word carries three things: an offset into a memory segment, a segment index just above that offset, and a privilege index that may share bits with the segment index. The block splits the word according to a selector register and looks up two tables. A 64-entry segment table gives a base and a length code per segment. A 16-entry privilege table gives a 4-bit privilege ID. The block then produces a full local address, the privilege ID and an error flag, one cycle after the request.

Software reaches both tables only indirectly. It writes an index register, then writes a value register, and the value lands in the entry that the index selects. Reading the value register returns the entry at the current index. A small two-state machine sequences configuration reads: `CFG_IDLE` moves to `CFG_RESP` on a read request, `CFG_RESP` stays there on a back-to-back read, and it returns to `CFG_IDLE` otherwise. The read response is valid while the machine is in `CFG_RESP`.

Top module: `inb_seg_xlat`

## Requirements
- R1: After reset, `out_valid` and `cfg_rvalid` are 0, the selector register reads 0, and every table entry is zero. A translation issued with no table programmed therefore returns `out_err`=1 and `out_addr`=0.
- R2: For a used entry, `out_addr` = (entry base << 16) OR (`in_addr` AND mask). The mask has (length code + 1) ones in its low bits, so a length code of 31 passes all 32 bits.
- R3: With selector field `seg_sel` (bits 3:0 of offset 0x2C), the segment index is the 6 address bits starting at bit `seg_sel`+16. Any index bit that falls above bit 31 reads as 0.
- R4: With selector field `priv_sel` (bits 11:8 of offset 0x2C), the privilege index is the 4 address bits starting at bit `priv_sel`+16, again with zeros above bit 31. `out_priv` is the privilege table entry at that index.
- R5: A lookup that hits an entry with length code 0 sets `out_err`=1 and forces `out_addr` to 0. A lookup that hits a used entry sets `out_err`=0.
- R6: The outputs for a request with `in_valid` high at one rising edge appear after that edge. `out_valid` is the previous cycle's `in_valid`, and the output fields hold their values while `in_valid` is low.
- R7: Writing offset 0x38 sets the segment index (bits 5:0). Writing offset 0x3C stores base = data[31:16] and length code = data[4:0] into the indexed entry.
- R8: A read (`cfg_rd` high with `cfg_wr` low) is answered in the next cycle with `cfg_rvalid`=1. Offset 0x3C reads {base, 11'b0, length code} of the indexed entry. Offsets 0x2C, 0x30 and 0x38 read back what was written to their fields.
- R9: Offset 0x30 sets the privilege index (bits 3:0). Writing offset 0x34 stores data[3:0] into the indexed privilege entry, and reading offset 0x34 returns that entry in bits 3:0.
- R10: A table write at a clock edge does not affect a translation sampled at that same edge. It does affect the translation sampled at the next edge.
- R11: A write to any other offset changes no state. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe (ignored while cfg_wr is high) |
| cfg_addr | input | 8 | Configuration register byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rvalid | output | 1 | Read response valid |
| cfg_rdata | output | 32 | Read response data |
| in_valid | input | 1 | Incoming address valid |
| in_addr | input | 32 | Incoming address word |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 32 | Translated local address |
| out_priv | output | 4 | Privilege ID from the privilege table |
| out_err | output | 1 | Hit on an unused segment entry |

## Verification
Most internal faults show up at the translated-address port one cycle after the request that exposes them.
- A segment entry written to the wrong slot gives a wrong base or a spurious error on the next request that indexes either slot.
- A misplaced index window moves the translation to another entry for addresses whose upper bits differ.
- A privilege index taken from the wrong bits shows up in `out_priv`.

Because the tables are read back through the value registers, a corrupted entry is also visible on `cfg_rdata` one cycle after the read. Same-cycle write-and-translate stimulus shows whether the table update lands one edge too early or too late.

// File: rtl/inb_xlat_pkg.sv
package inb_xlat_pkg;
    localparam int CFG_AW     = 8;
    localparam int CFG_DW     = 32;
    localparam int BASE_W     = 16;
    localparam int LEN_W      = 5;
    localparam int SEL_W      = 4;
    localparam int PRIV_W     = 4;
    localparam int OFS_FLOOR  = 16;

    localparam logic [CFG_AW-1:0] OFS_SEL      = 8'h2C;
    localparam logic [CFG_AW-1:0] OFS_PRIV_IDX = 8'h30;
    localparam logic [CFG_AW-1:0] OFS_PRIV_VAL = 8'h34;
    localparam logic [CFG_AW-1:0] OFS_SEG_IDX  = 8'h38;
    localparam logic [CFG_AW-1:0] OFS_SEG_VAL  = 8'h3C;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } seg_ent_t;

    localparam int SEG_ENT_W = BASE_W + LEN_W;

    typedef enum logic [0:0] {
        CFG_IDLE = 1'b0,
        CFG_RESP = 1'b1
    } cfg_state_t;
endpackage

// File: rtl/xlat_lut.sv
module xlat_lut #(
    parameter int DEPTH = 64,
    parameter int DW    = 21,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] aidx,
    output logic [DW-1:0] adata,
    input  logic [IW-1:0] bidx,
    output logic [DW-1:0] bdata
);
    logic [DW-1:0] ent_view [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [DW-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (we && (widx == IW'(e))) begin
                ent_q <= wdata;
            end
        end
        assign ent_view[e] = ent_q;
    end

    assign adata = ent_view[aidx];
    assign bdata = ent_view[bidx];
endmodule

// File: rtl/xlat_cfg.sv
module xlat_cfg
    import inb_xlat_pkg::*;
#(
    parameter int SEG_DEPTH  = 64,
    parameter int PRIV_DEPTH = 16,
    localparam int SEG_IW    = $clog2(SEG_DEPTH),
    localparam int PRIV_IW   = $clog2(PRIV_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic               cfg_rvalid,
    output logic [CFG_DW-1:0]  cfg_rdata,
    output logic [SEL_W-1:0]   seg_sel,
    output logic [SEL_W-1:0]   priv_sel,
    output logic [SEG_IW-1:0]  seg_cidx,
    output logic [PRIV_IW-1:0] priv_cidx,
    output logic               seg_we,
    output seg_ent_t           seg_wdata,
    output logic               priv_we,
    output logic [PRIV_W-1:0]  priv_wdata,
    input  seg_ent_t           seg_cent,
    input  logic [PRIV_W-1:0]  priv_cent
);
    cfg_state_t state_q, state_d;
    logic       rd_req;
    logic [CFG_DW-1:0] rd_mux;
    logic [CFG_DW-1:0] rdata_q;

    assign rd_req = cfg_rd && !cfg_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: if (rd_req) state_d = CFG_RESP;
            CFG_RESP: state_d = rd_req ? CFG_RESP : CFG_IDLE;
            default:  state_d = CFG_IDLE;
        endcase
    end

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_sel   <= '0;
            priv_sel  <= '0;
            seg_cidx  <= '0;
            priv_cidx <= '0;
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                OFS_SEL: begin
                    seg_sel  <= cfg_wdata[SEL_W-1:0];
                    priv_sel <= cfg_wdata[8 +: SEL_W];
                end
                OFS_PRIV_IDX: priv_cidx <= cfg_wdata[PRIV_IW-1:0];
                OFS_SEG_IDX:  seg_cidx  <= cfg_wdata[SEG_IW-1:0];
                default: ;
            endcase
        end
    end

    assign seg_we          = cfg_wr && (cfg_addr == OFS_SEG_VAL);
    assign seg_wdata.base  = cfg_wdata[CFG_DW-1 -: BASE_W];
    assign seg_wdata.len   = cfg_wdata[LEN_W-1:0];
    assign priv_we         = cfg_wr && (cfg_addr == OFS_PRIV_VAL);
    assign priv_wdata      = cfg_wdata[PRIV_W-1:0];

    always_comb begin
        rd_mux = '0;
        unique case (cfg_addr)
            OFS_SEL: begin
                rd_mux[SEL_W-1:0]   = seg_sel;
                rd_mux[8 +: SEL_W]  = priv_sel;
            end
            OFS_PRIV_IDX: rd_mux[PRIV_IW-1:0] = priv_cidx;
            OFS_PRIV_VAL: rd_mux[PRIV_W-1:0]  = priv_cent;
            OFS_SEG_IDX:  rd_mux[SEG_IW-1:0]  = seg_cidx;
            OFS_SEG_VAL: begin
                rd_mux[CFG_DW-1 -: BASE_W] = seg_cent.base;
                rd_mux[LEN_W-1:0]          = seg_cent.len;
            end
            default: rd_mux = '0;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    assign cfg_rvalid = (state_q == CFG_RESP);
    assign cfg_rdata  = rdata_q;
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
    import inb_xlat_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SEG_DEPTH  = 64,
    parameter int PRIV_DEPTH = 16,
    localparam int SEG_IW    = $clog2(SEG_DEPTH),
    localparam int PRIV_IW   = $clog2(PRIV_DEPTH),
    localparam int EXT_W     = ADDR_W + 2 * OFS_FLOOR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [SEL_W-1:0]   seg_sel,
    input  logic [SEL_W-1:0]   priv_sel,
    output logic [SEG_IW-1:0]  seg_lidx,
    output logic [PRIV_IW-1:0] priv_lidx,
    input  seg_ent_t           seg_lent,
    input  logic [PRIV_W-1:0]  priv_lval,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [PRIV_W-1:0]  out_priv,
    output logic               out_err
);
    logic [EXT_W-1:0]  ext_addr, seg_win, priv_win;
    logic [ADDR_W-1:0] ent_mask, base_full, xl_addr;
    logic              unused_hit;

    always_comb begin
        ext_addr  = EXT_W'(in_addr);
        seg_win   = ext_addr >> (int'(seg_sel) + OFS_FLOOR);
        priv_win  = ext_addr >> (int'(priv_sel) + OFS_FLOOR);
        seg_lidx  = seg_win[SEG_IW-1:0];
        priv_lidx = priv_win[PRIV_IW-1:0];
    end

    always_comb begin
        unused_hit = (seg_lent.len == '0);
        ent_mask   = {ADDR_W{1'b1}} >> (ADDR_W - 1 - int'(seg_lent.len));
        base_full  = {seg_lent.base, {(ADDR_W-BASE_W){1'b0}}};
        xl_addr    = unused_hit ? '0 : (base_full | (in_addr & ent_mask));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_priv  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= xl_addr;
                out_priv <= priv_lval;
                out_err  <= unused_hit;
            end
        end
    end
endmodule

// File: rtl/inb_seg_xlat.sv
module inb_seg_xlat
    import inb_xlat_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SEG_DEPTH  = 64,
    parameter int PRIV_DEPTH = 16,
    localparam int SEG_IW    = $clog2(SEG_DEPTH),
    localparam int PRIV_IW   = $clog2(PRIV_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_rvalid,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [3:0]        out_priv,
    output logic              out_err
);
    logic [SEL_W-1:0]   seg_sel, priv_sel;
    logic [SEG_IW-1:0]  seg_cidx, seg_lidx;
    logic [PRIV_IW-1:0] priv_cidx, priv_lidx;
    logic               seg_we, priv_we;
    seg_ent_t           seg_wdata, seg_cent, seg_lent;
    logic [PRIV_W-1:0]  priv_wdata, priv_cent, priv_lval;

    xlat_cfg #(.SEG_DEPTH(SEG_DEPTH), .PRIV_DEPTH(PRIV_DEPTH)) u_cfg (
        .clk, .rst_n, .cfg_wr, .cfg_rd, .cfg_addr, .cfg_wdata,
        .cfg_rvalid, .cfg_rdata, .seg_sel, .priv_sel, .seg_cidx, .priv_cidx,
        .seg_we, .seg_wdata, .priv_we, .priv_wdata, .seg_cent, .priv_cent
    );

    xlat_lut #(.DEPTH(SEG_DEPTH), .DW(SEG_ENT_W)) u_seg_lut (
        .clk, .rst_n, .we(seg_we), .widx(seg_cidx), .wdata(seg_wdata),
        .aidx(seg_cidx), .adata(seg_cent), .bidx(seg_lidx), .bdata(seg_lent)
    );

    xlat_lut #(.DEPTH(PRIV_DEPTH), .DW(PRIV_W)) u_priv_lut (
        .clk, .rst_n, .we(priv_we), .widx(priv_cidx), .wdata(priv_wdata),
        .aidx(priv_cidx), .adata(priv_cent), .bidx(priv_lidx), .bdata(priv_lval)
    );

    xlat_datapath #(.ADDR_W(ADDR_W), .SEG_DEPTH(SEG_DEPTH), .PRIV_DEPTH(PRIV_DEPTH)) u_dp (
        .clk, .rst_n, .in_valid, .in_addr, .seg_sel, .priv_sel,
        .seg_lidx, .priv_lidx, .seg_lent, .priv_lval,
        .out_valid, .out_addr, .out_priv, .out_err
    );
endmodule

// File: rtl/inb_seg_xlat_chk.sv
module inb_seg_xlat_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_rd,
    input logic [7:0]        cfg_addr,
    input logic              cfg_rvalid,
    input logic [31:0]       cfg_rdata,
    input logic              in_valid,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_err
);
    logic rd_req, mapped;
    assign rd_req = cfg_rd && !cfg_wr;
    assign mapped = (cfg_addr == 8'h2C) || (cfg_addr == 8'h30) || (cfg_addr == 8'h34)
                 || (cfg_addr == 8'h38) || (cfg_addr == 8'h3C);

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));
    p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == '0));
    p_rd_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> cfg_rvalid);
    p_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !cfg_rvalid);
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mapped) |=> (cfg_rdata == 32'h0));
endmodule

bind inb_seg_xlat inb_seg_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .out_valid(out_valid), .out_addr(out_addr),
    .out_err(out_err)
);

// File: tb/inb_seg_xlat_tb.sv
module inb_seg_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [3:0]  out_priv;
    logic        out_err;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [15:0] m_base [64];
    logic [4:0]  m_len  [64];
    logic [3:0]  m_priv [16];
    logic [3:0]  m_segsel = '0, m_privsel = '0;

    inb_seg_xlat u_dut (.*);

    always #2 clk = ~clk;

    // {seg_sel, priv_sel, address}
    localparam logic [39:0] VEC [12] = '{
        {4'd8,  4'd12, 32'h7567_89A0},
        {4'd8,  4'd12, 32'h1234_5678},
        {4'd8,  4'd12, 32'h0200_0ABC},
        {4'd8,  4'd12, 32'h0800_0000},
        {4'd6,  4'd12, 32'h00C0_1234},
        {4'd6,  4'd0,  32'h4567_89A0},
        {4'd12, 4'd12, 32'h9ABC_DEF0},
        {4'd12, 4'd14, 32'hC000_0001},
        {4'd9,  4'd12, 32'hFFFF_FFFF},
        {4'd15, 4'd15, 32'h8000_0000},
        {4'd0,  4'd3,  32'h00AB_CDEF},
        {4'd13, 4'd12, 32'h3000_0000}
    };

    function automatic logic [5:0] m_sidx(input logic [31:0] a);
        logic [47:0] e;
        e = {16'h0, a} >> (int'(m_segsel) + 16);
        return e[5:0];
    endfunction

    function automatic logic [3:0] m_pidx(input logic [31:0] a);
        logic [47:0] e;
        e = {16'h0, a} >> (int'(m_privsel) + 16);
        return e[3:0];
    endfunction

    function automatic logic [31:0] m_addr(input logic [31:0] a);
        logic [5:0]  ix;
        logic [31:0] mk;
        ix = m_sidx(a);
        if (m_len[ix] == 5'd0) return 32'h0;
        mk = 32'hFFFF_FFFF >> (31 - int'(m_len[ix]));
        return {m_base[ix], 16'h0} | (a & mk);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        check("R8 rvalid", {31'h0, cfg_rvalid}, 32'h1);
        d = cfg_rdata;
    endtask

    task automatic set_sel(input logic [3:0] s, input logic [3:0] p);
        cfg_write(8'h2C, {20'h0, p, 4'h0, s});
        m_segsel = s; m_privsel = p;
    endtask

    task automatic put_seg(input int i, input logic [15:0] b, input logic [4:0] l);
        cfg_write(8'h38, 32'(i));
        cfg_write(8'h3C, {b, 11'h0, l});
        m_base[i] = b; m_len[i] = l;
    endtask

    task automatic xlate(input string req, input logic [31:0] a);
        logic [31:0] ea;
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        ea = m_addr(a);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'h0, out_valid}, 32'h1);
        check({req, " addr"}, out_addr, ea);
        check({req, " err"}, {31'h0, out_err}, {31'h0, (m_len[m_sidx(a)] == 5'd0)});
        check({req, " priv"}, {28'h0, out_priv}, {28'h0, m_priv[m_pidx(a)]});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 64; i++) begin m_base[i] = '0; m_len[i] = '0; end
        for (int i = 0; i < 16; i++) m_priv[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out_valid", {31'h0, out_valid}, 32'h0);
        check("R1 rvalid", {31'h0, cfg_rvalid}, 32'h0);
        cfg_read(8'h2C, rd);
        check("R1 selector", rd, 32'h0);
        xlate("R1 empty table R5", 32'h1234_5678);

        // R7/R9: program tables
        for (int i = 0; i < 64; i++) begin
            if ((i & 8) != 0) put_seg(i, 16'h0, 5'd0);
            else put_seg(i, 16'h8000 + 16'((i & 7) * 16'h200), 5'd23);
        end
        put_seg(2, 16'h0C00, 5'd8);
        put_seg(3, 16'h0000, 5'd31);
        put_seg(9, 16'h1000, 5'd27);
        for (int i = 0; i < 16; i++) begin
            cfg_write(8'h30, 32'(i));
            cfg_write(8'h34, 32'(15 - i));
            m_priv[i] = 4'(15 - i);
        end

        // readback R8/R7/R9
        cfg_write(8'h38, 32'd5);
        cfg_read(8'h3C, rd);
        check("R7 seg value readback", rd, {16'h8A00, 11'h0, 5'd23});
        cfg_read(8'h38, rd);
        check("R8 seg index readback", rd, 32'd5);
        cfg_write(8'h30, 32'd3);
        cfg_read(8'h34, rd);
        check("R9 priv value readback", rd, 32'd12);
        set_sel(4'd9, 4'd12);
        cfg_read(8'h2C, rd);
        check("R8 selector readback", rd, 32'h0000_0C09);

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < 12; v++) begin
            if (VEC[v][39:36] != m_segsel || VEC[v][35:32] != m_privsel)
                set_sel(VEC[v][39:36], VEC[v][35:32]);
            xlate("R2/R3/R4/R5 vector", VEC[v][31:0]);
        end

        // R6: outputs hold while in_valid low
        @(negedge clk);
        @(negedge clk);
        check("R6 no valid", {31'h0, out_valid}, 32'h0);
        check("R6 addr held", out_addr, m_addr(VEC[11][31:0]));

        // R10: write and translate in the same cycle
        set_sel(4'd12, 4'd12);
        cfg_write(8'h38, 32'd9);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'h3C; cfg_wdata = {16'h7700, 11'h0, 5'd20};
        in_valid = 1'b1; in_addr = 32'h9000_0010;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R10 old entry used", out_addr, 32'h1000_0010);
        m_base[9] = 16'h7700; m_len[9] = 5'd20;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 new entry used", out_addr, 32'h7700_0010);

        // R11: unmapped offsets
        cfg_write(8'h40, 32'hFFFF_FFFF);
        cfg_write(8'h00, 32'hFFFF_FFFF);
        cfg_read(8'h40, rd);
        check("R11 unmapped read", rd, 32'h0);
        cfg_read(8'h2C, rd);
        check("R11 selector unchanged", rd, 32'h0000_0C0C);
        cfg_read(8'h3C, rd);
        check("R11 entry unchanged", rd, {16'h7700, 11'h0, 5'd20});
        xlate("R11 translation unchanged", 32'h9000_0010);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule